// File: doc/BRIEF.md
# Preset Interval Timer Cell

This cell behaves like the timer element of a relay-ladder controller. An external rung evaluator supplies a single rung condition; the cell counts whole pulses of a one-second time base while that condition is true. It compares the count against a preset and raises a done flag when the preset is reached. Downstream rung logic then uses that flag.

A mode input selects between two retention policies. In on-delay mode a false rung discards the count and the done flag. In retentive mode both survive a false rung, and timing resumes from the held count when the rung is true again. Only a clear request can empty a retentive timer, and that request is honoured only while the rung is false.

Counts and presets are 14-bit unsigned values limited to 0..9999. The preset, the rung evaluation and any display of the value are handled outside the cell.

Top module: `preset_timer`

## Requirements
- R1: `enableOut` shows the value `rungTrue` had at the previous rising clock edge, in both modes.
- R2: With `rungTrue` high, each cycle with `tick` high and `accOut` below the effective preset increments `accOut` by one at the next edge. Without `tick`, or once `accOut` has reached the preset, `accOut` does not change.
- R3: In on-delay mode (`modeRetain` = 0), a cycle with `rungTrue` low clears `accOut` to 0 and `doneOut` to 0 at the next edge.
- R4: `doneOut` rises at the same edge at which `accOut` becomes equal to the effective preset.
- R5: In retentive mode (`modeRetain` = 1), a cycle with `rungTrue` low and `clearReq` low leaves `accOut` and `doneOut` unchanged. Later ticks with the rung true continue from the held count.
- R6: A cycle with `clearReq` high and `rungTrue` low clears `accOut`, `doneOut` and `enableOut` at the next edge.
- R7: `clearReq` has no effect in any cycle in which `rungTrue` is high.
- R8: A `presetIn` above 9999 acts as a preset of 9999, and `accOut` never exceeds 9999.
- R9: With an effective preset of 0, `doneOut` is high after the first edge at which `rungTrue` is high, with no tick needed.
- R10: A synchronous active-high `rst` drives `accOut`, `doneOut` and `enableOut` to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| modeRetain | input | 1 | 0 = on-delay, 1 = retentive accumulate |
| rungTrue | input | 1 | Rung condition from the ladder evaluator |
| tick | input | 1 | One-cycle pulse of the one-second time base |
| clearReq | input | 1 | Clear request, honoured only while the rung is false |
| presetIn | input | 14 | Preset value, saturated to 9999 |
| accOut | output | 14 | Accumulated tick count |
| enableOut | output | 1 | Enable status, follows the rung |
| doneOut | output | 1 | Done status |

## Verification
Two functions can land in the same cycle: the clear request and the counting path. The bench raises `clearReq` while the rung is true, including cycles where a tick would take the count to the preset. The count must advance and the done flag must rise exactly as they would without the request. The bench also raises the request on the very cycle the rung drops in retentive mode, where the count must be cleared rather than held. Random mixes of rung, tick, clear and mode changes cover the remaining overlaps. Each output is judged every cycle against a bench model built from the requirements.

// File: rtl/preset_timer_pkg.sv
package preset_timer_pkg;
  // control-to-datapath strobes for one clock cycle
  typedef struct packed {
    logic incAcc;    // advance the count by one
    logic clrAcc;    // empty the count
    logic evalDone;  // rung true: recompute done from the next count
    logic keepDone;  // retentive: an already set done stays set
    logic clrDone;   // drop the done flag
  } tmrStrobe_t;
endpackage

// File: rtl/preset_timer_ctrl.sv
module preset_timer_ctrl
  import preset_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       modeRetain,
  input  logic       rungTrue,
  input  logic       tick,
  input  logic       clearReq,
  input  logic       reached,
  output tmrStrobe_t strobe,
  output logic       enableQ
);
  logic dropState;

  // the rung being false discards state in on-delay mode, or on a clear request
  assign dropState = !rungTrue && (!modeRetain || clearReq);

  always_comb begin
    strobe          = '0;
    strobe.incAcc   = rungTrue && tick && !reached;
    strobe.clrAcc   = dropState;
    strobe.evalDone = rungTrue;
    strobe.keepDone = modeRetain;
    strobe.clrDone  = dropState;
  end

  always_ff @(posedge clk) begin
    if (rst) enableQ <= 1'b0;
    else     enableQ <= rungTrue;
  end

  assert_enable_on_R1: assert property (@(posedge clk) disable iff (rst)
    rungTrue |=> enableQ);
  assert_enable_off_R1: assert property (@(posedge clk) disable iff (rst)
    !rungTrue |=> !enableQ);
endmodule

// File: rtl/preset_timer_dp.sv
module preset_timer_dp
  import preset_timer_pkg::*;
#(
  parameter int MAX_COUNT = 9999,
  parameter int W         = $clog2(MAX_COUNT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  tmrStrobe_t   strobe,
  input  logic [W-1:0] presetIn,
  output logic [W-1:0] accQ,
  output logic         doneQ,
  output logic         reached
);
  localparam logic [W-1:0] CAP = W'(MAX_COUNT);

  logic [W-1:0] presetSat;
  logic [W-1:0] accNext;
  logic         doneNext;

  assign presetSat = (presetIn > CAP) ? CAP : presetIn;
  assign reached   = (accQ >= presetSat);

  always_comb begin
    accNext = accQ;
    if (strobe.clrAcc)      accNext = '0;
    else if (strobe.incAcc) accNext = accQ + 1'b1;
  end

  always_comb begin
    doneNext = doneQ;
    if (strobe.clrDone)
      doneNext = 1'b0;
    else if (strobe.evalDone)
      doneNext = (accNext >= presetSat) || (strobe.keepDone && doneQ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      accQ  <= accNext;
      doneQ <= doneNext;
    end
  end

  assert_acc_range_R8: assert property (@(posedge clk) disable iff (rst)
    accQ <= CAP);
endmodule

// File: rtl/preset_timer.sv
module preset_timer
  import preset_timer_pkg::*;
#(
  parameter int MAX_COUNT = 9999,
  parameter int W         = $clog2(MAX_COUNT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         modeRetain,
  input  logic         rungTrue,
  input  logic         tick,
  input  logic         clearReq,
  input  logic [W-1:0] presetIn,
  output logic [W-1:0] accOut,
  output logic         enableOut,
  output logic         doneOut
);
  tmrStrobe_t strobe;
  logic       reached;

  preset_timer_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .modeRetain (modeRetain),
    .rungTrue   (rungTrue),
    .tick       (tick),
    .clearReq   (clearReq),
    .reached    (reached),
    .strobe     (strobe),
    .enableQ    (enableOut)
  );

  preset_timer_dp #(.MAX_COUNT(MAX_COUNT), .W(W)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .presetIn (presetIn),
    .accQ     (accOut),
    .doneQ    (doneOut),
    .reached  (reached)
  );

  assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (rungTrue && !tick) |=> $stable(accOut));
  assert_ondelay_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (!modeRetain && !rungTrue) |=> (accOut == '0 && !doneOut));
  assert_retain_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (modeRetain && !rungTrue && !clearReq) |=> ($stable(accOut) && $stable(doneOut)));
  assert_clear_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!rungTrue && clearReq) |=> (accOut == '0 && !doneOut && !enableOut));
  assert_clear_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (rungTrue && clearReq) |=> (accOut >= $past(accOut) && enableOut));
  assert_zero_preset_R9: assert property (@(posedge clk) disable iff (rst)
    (rungTrue && presetIn == '0) |=> doneOut);
endmodule

// File: tb/test_preset_timer.sv
`timescale 1ns/1ps
module test_preset_timer;
  logic        clk = 1'b0;
  logic        rst, modeRetain, rungTrue, tick, clearReq;
  logic [13:0] presetIn;
  logic [13:0] accOut;
  logic        enableOut, doneOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int mAcc = 0;
  bit mDone = 0, mEn = 0;

  always #2.5 clk = ~clk;

  preset_timer i_preset_timer (
    .clk(clk), .rst(rst), .modeRetain(modeRetain), .rungTrue(rungTrue),
    .tick(tick), .clearReq(clearReq), .presetIn(presetIn),
    .accOut(accOut), .enableOut(enableOut), .doneOut(doneOut)
  );

  function automatic int effPreset(input int p);
    return (p > 9999) ? 9999 : p;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, advance the model, sample at the next negedge
  task automatic step(input bit r, input bit m, input bit rg, input bit tk,
                      input bit cl, input int pr);
    string tag;
    int pre;
    rst = r; modeRetain = m; rungTrue = rg; tick = tk; clearReq = cl;
    presetIn = 14'(pr);
    pre = effPreset(pr);
    if (r)                tag = "R10";
    else if (rg && cl)    tag = "R7";
    else if (!rg && !m)   tag = "R3";
    else if (!rg && cl)   tag = "R6";
    else if (!rg)         tag = "R5";
    else if (pre == 0)    tag = "R9";
    else if (pr > 9999)   tag = "R8";
    else                  tag = "R2";
    if (r) begin
      mAcc = 0; mDone = 0; mEn = 0;
    end else begin
      mEn = rg;
      if (rg) begin
        if (tk && mAcc < pre) mAcc++;
        mDone = (mAcc >= pre) || (m && mDone);
      end else if (!m || cl) begin
        mAcc = 0; mDone = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "accOut", int'(accOut), mAcc);
    check(r ? "R10" : "R1", "enableOut", int'(enableOut), int'(mEn));
    check((rg && !r) ? "R4" : tag, "doneOut", int'(doneOut), int'(mDone));
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    rst = 1; modeRetain = 0; rungTrue = 0; tick = 0; clearReq = 0; presetIn = '0;
    @(negedge clk);
    // R10: reset state
    step(1, 0, 1, 1, 0, 3);
    step(1, 1, 1, 1, 0, 3);

    // on-delay, preset 3: R2 counting, R4 done with acc, hold at preset, R3 drop
    for (int i = 0; i < 5; i++) step(0, 0, 1, 1, 0, 3);
    step(0, 0, 1, 0, 0, 3);
    step(0, 0, 0, 1, 0, 3);
    // R3: dropping before completion
    step(0, 0, 1, 1, 0, 3);
    step(0, 0, 0, 0, 0, 3);

    // retentive, preset 5: R5 hold and resume
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 0, 5);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 1, 0, 5);
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 0, 5);
    step(0, 1, 0, 0, 0, 5);
    // R7: clear while rung true ignored, even with a tick at the preset
    step(0, 1, 1, 1, 1, 5);
    step(0, 1, 1, 0, 1, 5);
    // R6: clear on the cycle the rung drops
    step(0, 1, 0, 0, 1, 5);
    // R7: clear during counting toward preset
    step(0, 1, 1, 1, 1, 2);
    step(0, 1, 1, 1, 1, 2);
    step(0, 1, 0, 0, 0, 2);

    // R9: zero preset, done without tick in both modes
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 1, 0);
    step(0, 1, 1, 0, 0, 0);

    // R8: preset above range saturates to 9999
    step(0, 0, 0, 0, 0, 15000);
    for (int i = 0; i < 10002; i++) step(0, 0, 1, 1, 0, 15000);
    check("R8", "accOut saturated", int'(accOut), 9999);
    check("R8", "doneOut saturated", int'(doneOut), 1);
    step(0, 0, 0, 0, 0, 15000);

    // constrained random mix
    for (int i = 0; i < 6000; i++) begin
      bit r, m, rg, tk, cl;
      int pr;
      r  = ($urandom % 200) == 0;
      m  = (i / 500) % 2 == 1 ? (($urandom % 40) != 0) : (($urandom % 40) == 0);
      rg = ($urandom % 4) != 0;
      tk = ($urandom % 3) == 0;
      cl = ($urandom % 6) == 0;
      pr = (($urandom % 50) == 0) ? 10000 + ($urandom % 6000) : ($urandom % 12);
      if (pr > 16383) pr = 16383;
      step(r, m, rg, tk, cl, pr);
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  end
endmodule